// File: doc/BRIEF.md
# Status and Alarm Register Bank with Alert

This block keeps the fault picture of a power-conversion target for a host on a management bus. Five live fault conditions (fan failure, thermal warning, thermal shutdown, overvoltage shutdown and internal fault) and an automatic-restart indication arrive asynchronously. Each one passes through a two-flop synchroniser. Two communication error pulses (checksum failure and bad data) arrive from the bus logic in the block's own clock domain.

Live status bits follow the present condition rather than freezing at the first fault. Communication errors latch until the host sends a clear command. The restart flag and a change flag latch on their own events. The change flag drives an active-low alert line.

The bus logic selects a register with a small address and reads it combinationally. It then pulses a read-complete strobe, and this strobe clears the status view. A clear strobe wipes every register.

Top module: `statusAlarmBank`

## Requirements
- R1: Each fault input and the restart input pass through two flip-flops before use. A change applied before a clock edge shows in the registers after the third rising edge, and not after the second.
- R2: Register 0 (rdAddr = 0) holds the live status. Data bit i (i = 0..4) follows faultIn[i], where bit 0 is fan, bit 1 is thermal warning, bit 2 is thermal shutdown, bit 3 is overvoltage shutdown and bit 4 is internal fault. A bit is set while its condition is present and clears when the condition goes away.
- R3: Register 1 (rdAddr = 1) holds the communication errors: bit 0 is checksum failure and bit 1 is bad data. A one-cycle pulse on commPulse sets the bit. A read-complete strobe does not clear it; only a clear strobe does.
- R4: Register 2 (rdAddr = 2), bit 0, is the change flag. It is set by any of these events:
  - a synchronised live fault that rises or falls;
  - a rising synchronised restart input;
  - a communication pulse that sets a bit that is currently clear.
  A pulse on an error bit that is already set is not a change.
- R5: A read-complete strobe clears the live status bits, the restart flag and the change flag for one cycle. Conditions that are still present show again one cycle later. The communication errors are kept.
- R6: A clear strobe clears the live status bits, the restart flag, the communication errors and the change flag. Conditions that are still present return one cycle later. A communication pulse in the same cycle as the clear leaves its bit set.
- R7: alertN is low while the change flag is set. It returns high in the cycle after a read-complete or clear strobe, unless a new change event coincides with that strobe.
- R8: If a live fault rises in the same cycle as a read-complete strobe, that fault's status bit stays set and the change flag stays set.
- R9: The restart flag (register 0, bit 5) sets on a rising synchronised restart input. It stays set after the input falls, until a read-complete or clear strobe.
- R10: After reset every register reads zero and alertN is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultIn | input | 5 | Asynchronous live fault conditions |
| restartIn | input | 1 | Asynchronous automatic-restart indication |
| commPulse | input | 2 | Communication error pulses (bit 0 checksum, bit 1 data) |
| readDone | input | 1 | Host read of the status registers completed |
| clearCmd | input | 1 | Clear-everything command strobe |
| rdAddr | input | 2 | Register select for the read port |
| rdData | output | 8 | Selected register contents, zero-extended |
| alertN | output | 1 | Active-low alert, low while a change is pending |

## Verification
The collision that matters is a read-complete strobe landing in the same cycle as a newly rising fault. The bench provokes it by changing a fault input and raising readDone exactly two edges later, so the strobe meets the edge at which the synchronised rise is registered. The bench judges the outcome by reading register 0: only the newly risen bit must survive, while bits that were steadily active must read zero. The change flag and the alert must remain asserted. A second collision pairs a clear strobe with a communication pulse, and only the pulsed error bit must remain.

// File: rtl/statusAlarmPkg.sv
package statusAlarmPkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic clearAll;   // wipe every register, live bits re-set next cycle
    logic readClear;  // host read completed, clear the status view
  } ctrlStrobes_t;

  // Register map indices for the read port.
  localparam int REG_STATUS  = 0;
  localparam int REG_COMM    = 1;
  localparam int REG_CHANGED = 2;

endpackage

// File: rtl/syncBits.sv
module syncBits #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import statusAlarmPkg::*;
#(
  parameter int LIVE_W      = 5,
  parameter int COMM_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LIVE_W-1:0] faultIn,
  input  logic              restartIn,
  input  logic [COMM_W-1:0] commPulse,
  input  ctrlStrobes_t      strobes,
  input  logic              changedFlag,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              changeEvt
);

  localparam int IN_W = LIVE_W + 1;

  logic [IN_W-1:0]   rawIn;
  logic [IN_W-1:0]   syncIn;
  logic [IN_W-1:0]   prevIn;
  logic [LIVE_W-1:0] liveNow;
  logic [LIVE_W-1:0] riseLive;
  logic [LIVE_W-1:0] toggleLive;
  logic              restartRise;
  logic [COMM_W-1:0] commNew;
  logic [LIVE_W-1:0] statusReg;
  logic              restartFlag;
  logic [COMM_W-1:0] commReg;

  assign rawIn = {restartIn, faultIn};

  syncBits #(.W(IN_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncIn)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevIn <= '0;
    else       prevIn <= syncIn;
  end

  assign liveNow     = syncIn[LIVE_W-1:0];
  assign riseLive    = liveNow & ~prevIn[LIVE_W-1:0];
  assign toggleLive  = liveNow ^ prevIn[LIVE_W-1:0];
  assign restartRise = syncIn[LIVE_W] & ~prevIn[LIVE_W];
  assign commNew     = commPulse & ~commReg;
  assign changeEvt   = (|toggleLive) | restartRise | (|commNew);

  // Live status: tracks the condition, a strobe blanks it for one cycle,
  // a fault rising in the strobe cycle survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  statusReg <= '0;
    else if (strobes.clearAll)  statusReg <= riseLive;
    else if (strobes.readClear) statusReg <= riseLive;
    else                        statusReg <= liveNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                       restartFlag <= 1'b0;
    else if (strobes.clearAll || strobes.readClear)  restartFlag <= restartRise;
    else                                             restartFlag <= restartFlag | restartRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 commReg <= '0;
    else if (strobes.clearAll) commReg <= commPulse;
    else                       commReg <= commReg | commPulse;
  end

  always_comb begin
    rdData = '0;
    case (int'(rdAddr))
      REG_STATUS:  rdData = DATA_W'({restartFlag, statusReg});
      REG_COMM:    rdData = DATA_W'(commReg);
      REG_CHANGED: rdData = DATA_W'(changedFlag);
      default:     rdData = '0;
    endcase
  end

  // R3: a latched communication error survives every cycle without a clear
  a_r3_comm_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clearAll |=> ((commReg & $past(commReg)) == $past(commReg)));

  // R5: a read strobe with nothing rising leaves the live view blank
  a_r5_read_blanks: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readClear && !strobes.clearAll && riseLive == '0) |=> (statusReg == '0));

  // R6: a clear with no coinciding pulse empties the error register
  a_r6_clear_comm: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearAll && commPulse == '0) |=> (commReg == '0));

  // R8: a fault rising alongside a read strobe keeps its bit
  a_r8_rise_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readClear |=> ((statusReg & $past(riseLive)) == $past(riseLive)));

  // R9: the restart flag holds until a strobe
  a_r9_restart_hold: assert property (@(posedge clk) disable iff (!rstN)
    (restartFlag && !strobes.clearAll && !strobes.readClear) |=> restartFlag);

endmodule

// File: rtl/statusControl.sv
module statusControl
  import statusAlarmPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         readDone,
  input  logic         clearCmd,
  input  logic         changeEvt,
  output ctrlStrobes_t strobes,
  output logic         changedFlag,
  output logic         alertN
);

  always_comb begin
    strobes.clearAll  = clearCmd;
    strobes.readClear = readDone & ~clearCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   changedFlag <= 1'b0;
    else if (readDone || clearCmd) changedFlag <= changeEvt;
    else                         changedFlag <= changedFlag | changeEvt;
  end

  assign alertN = ~changedFlag;

  // R7: a change event pulls the alert low on the next cycle
  a_r7_alert_on_change: assert property (@(posedge clk) disable iff (!rstN)
    changeEvt |=> !alertN);

  // R7: a strobe with no change event releases the alert
  a_r7_alert_release: assert property (@(posedge clk) disable iff (!rstN)
    ((readDone || clearCmd) && !changeEvt) |=> alertN);

  // R4: the change flag only rises on a change event
  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changedFlag) |-> $past(changeEvt));

endmodule

// File: rtl/statusAlarmBank.sv
module statusAlarmBank
  import statusAlarmPkg::*;
#(
  parameter int LIVE_W      = 5,
  parameter int COMM_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LIVE_W-1:0] faultIn,
  input  logic              restartIn,
  input  logic [COMM_W-1:0] commPulse,
  input  logic              readDone,
  input  logic              clearCmd,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              alertN
);

  ctrlStrobes_t strobes;
  logic         changedFlag;
  logic         changeEvt;

  statusControl i_control (
    .clk         (clk),
    .rstN        (rstN),
    .readDone    (readDone),
    .clearCmd    (clearCmd),
    .changeEvt   (changeEvt),
    .strobes     (strobes),
    .changedFlag (changedFlag),
    .alertN      (alertN)
  );

  statusDatapath #(
    .LIVE_W      (LIVE_W),
    .COMM_W      (COMM_W),
    .SYNC_STAGES (SYNC_STAGES),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .faultIn     (faultIn),
    .restartIn   (restartIn),
    .commPulse   (commPulse),
    .strobes     (strobes),
    .changedFlag (changedFlag),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .changeEvt   (changeEvt)
  );

  // R10: alert idle high while in reset
  a_r10_reset_alert: assert property (@(posedge clk) !rstN |-> alertN);

endmodule

// File: tb/test_statusAlarmBank.sv
module test_statusAlarmBank;

  localparam int CLK_PERIOD = 10;
  localparam int LIVE_W = 5;
  localparam int COMM_W = 2;

  logic              clk = 1'b0;
  logic              rstN;
  logic [LIVE_W-1:0] faultIn;
  logic              restartIn;
  logic [COMM_W-1:0] commPulse;
  logic              readDone;
  logic              clearCmd;
  logic [1:0]        rdAddr;
  logic [7:0]        rdData;
  logic              alertN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusAlarmBank i_statusAlarmBank (
    .clk       (clk),
    .rstN      (rstN),
    .faultIn   (faultIn),
    .restartIn (restartIn),
    .commPulse (commPulse),
    .readDone  (readDone),
    .clearCmd  (clearCmd),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .alertN    (alertN)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic readReg(input int addr, output int val);
    rdAddr = 2'(addr);
    #1;
    val = int'(rdData);
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic strobeRead();
    readDone = 1'b1;
    @(negedge clk);
    readDone = 1'b0;
  endtask

  task automatic strobeClear();
    clearCmd = 1'b1;
    @(negedge clk);
    clearCmd = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v;
    int prev;
    rstN = 1'b0; faultIn = '0; restartIn = 1'b0; commPulse = '0;
    readDone = 1'b0; clearCmd = 1'b0; rdAddr = '0;
    waitEdges(3);
    // R10: reset state
    for (int a = 0; a < 4; a++) begin
      readReg(a, v); check("R10 reg after reset", v, 0);
    end
    check("R10 alert after reset", int'(alertN), 1);
    rstN = 1'b1;
    waitEdges(2);

    // R1: two-flop delay
    faultIn = 5'b00001;
    waitEdges(2);
    readReg(0, v); check("R1 not visible after two edges", v, 0);
    waitEdges(1);
    readReg(0, v); check("R1 visible after three edges", v, 1);
    strobeRead();
    faultIn = '0;
    waitEdges(3);
    strobeRead();
    waitEdges(1);

    // R2/R4/R5/R7: sweep every fault pattern
    prev = 0;
    for (int p = 0; p < 32; p++) begin
      faultIn = 5'(p);
      waitEdges(3);
      readReg(0, v); check("R2 live status", v, p);
      readReg(2, v); check("R4 change flag", v, (p != prev) ? 1 : 0);
      check("R7 alert follows change", int'(alertN), (p != prev) ? 0 : 1);
      strobeRead();
      readReg(0, v); check("R5 read blanks status", v, 0);
      readReg(2, v); check("R5 read clears change flag", v, 0);
      check("R7 alert released by read", int'(alertN), 1);
      @(negedge clk);
      readReg(0, v); check("R5 live status returns", v, p);
      prev = p;
    end
    faultIn = '0;
    waitEdges(3);
    strobeRead();
    waitEdges(1);

    // R3: communication errors
    commPulse = 2'b01; @(negedge clk); commPulse = '0;
    readReg(1, v); check("R3 checksum error latched", v, 1);
    readReg(2, v); check("R4 new error is a change", v, 1);
    strobeRead();
    readReg(1, v); check("R3 read keeps error", v, 1);
    commPulse = 2'b01; @(negedge clk); commPulse = '0;
    readReg(2, v); check("R4 repeated error is no change", v, 0);
    commPulse = 2'b10; @(negedge clk); commPulse = '0;
    readReg(1, v); check("R3 both errors latched", v, 3);
    strobeClear();
    readReg(1, v); check("R6 clear empties errors", v, 0);
    commPulse = 2'b10; clearCmd = 1'b1;
    @(negedge clk);
    commPulse = '0; clearCmd = 1'b0;
    readReg(1, v); check("R6 pulse wins over clear", v, 2);
    strobeClear();

    // R6: clear with live faults present
    faultIn = 5'b10101;
    waitEdges(3);
    commPulse = 2'b01; @(negedge clk); commPulse = '0;
    strobeClear();
    readReg(0, v); check("R6 clear blanks status", v, 0);
    readReg(1, v); check("R6 clear empties errors", v, 0);
    readReg(2, v); check("R6 clear drops change flag", v, 0);
    check("R7 alert released by clear", int'(alertN), 1);
    @(negedge clk);
    readReg(0, v); check("R6 live status returns", v, 5'b10101);

    // R8: fault rise coinciding with read strobe
    faultIn = 5'b10111;
    waitEdges(2);
    strobeRead();
    readReg(0, v); check("R8 rising bit survives read", v, 5'b00010);
    readReg(2, v); check("R8 change flag survives read", v, 1);
    check("R8 alert stays low", int'(alertN), 0);
    @(negedge clk);
    readReg(0, v); check("R8 full status returns", v, 5'b10111);
    faultIn = '0;
    waitEdges(3);
    strobeClear();
    waitEdges(1);

    // R9: restart flag
    restartIn = 1'b1;
    waitEdges(3);
    readReg(0, v); check("R9 restart flag set", v, 32);
    readReg(2, v); check("R4 restart is a change", v, 1);
    restartIn = 1'b0;
    waitEdges(3);
    readReg(0, v); check("R9 restart flag holds", v, 32);
    strobeRead();
    readReg(0, v); check("R9 read clears restart flag", v, 0);
    @(negedge clk);
    readReg(0, v); check("R9 restart flag stays clear", v, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule